// File: doc/BRIEF.md
# Serial ADC Sample Reader

This block is the host-side master for a 12-bit successive-approximation converter with a three-wire serial output. When `start` is pulsed, it drives chip select low to freeze the input and begin a conversion. It keeps the serial clock low until the conversion is known to be complete. Completion is recognised in one of two ways, picked per read by `edgeMode`. In edge mode the converter raises its data line. In timeout mode a fixed worst-case conversion time is waited out.

The reader then runs exactly thirteen serial clock cycles in mode 0: the clock idles low, the converter moves its data on falling edges, and the reader captures on rising edges. The first captured bit is the converter's framing marker, which must be 1. The remaining twelve bits form the sample, most significant bit first. Chip select goes high together with the thirteenth falling edge, so no padding bits are ever clocked. The sample appears with a one-cycle `valid` strobe.

A minimum chip-select-high interval is then enforced before another read can start. The serial clock half-period, the conversion timeout and that interval are all counted in system clock cycles.

Top module: `adcSampleReader`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, `valid`, `busy` and `frameErr` are 0, and `result` is 0.
- R2: A `start` pulse seen while idle drives `csN` low and `busy` high from the next cycle. `sclk` stays low until end of conversion. A `start` seen while `busy` is 1 has no effect: that read still gives one `valid` and 13 clock cycles.
- R3: With `edgeMode` = 1, the first rising edge of `sclk` comes `HALF_CYC`+1 cycles after the cycle in which `sdi` first goes high with `csN` low.
- R4: With `edgeMode` = 0, `sdi` is not watched during conversion. The first rising edge of `sclk` comes exactly `CONV_CYC`+`HALF_CYC` cycles after `csN` falls.
- R5: Every read that is not aborted gives exactly 13 rising edges of `sclk`. Every high phase, and every low phase between rising edges, lasts `HALF_CYC` cycles. `sclk` is never high while `csN` is high.
- R6: `sdi` is captured on each rising edge of `sclk`. The first captured bit is the framing marker. The next 12 captured bits become `result[11:0]`, with the first of them in bit 11.
- R7: `csN` rises in the same cycle as the 13th falling edge of `sclk`. `valid` is 1 for exactly one cycle, starting in that same cycle, while `result` holds the new sample.
- R8: `frameErr` is cleared when a read starts. At the end of a read it is set to the inverse of the framing marker, so it becomes 1 when the marker was 0. The sample is still delivered.
- R9: If `edgeMode` = 1 and `sdi` has not gone high by `CONV_CYC` cycles after `csN` falls, the read is aborted. `csN` returns high, `frameErr` becomes 1, no `sclk` edge occurs and no `valid` is produced.
- R10: After `csN` rises, `busy` stays 1 for exactly `GAP_CYC` cycles while `csN` is 1. `csN` therefore stays high for at least `GAP_CYC`+1 cycles before it can fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one read; taken only while idle |
| edgeMode | input | 1 | 1: end of conversion from `sdi` rising; 0: fixed timeout |
| sdi | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles low |
| result | output | DATA_W | Last sample read, MSB first on the wire |
| valid | output | 1 | One-cycle strobe marking a new `result` |
| busy | output | 1 | High from the accepted start to the end of the chip-select-high interval |
| frameErr | output | 1 | Framing marker was 0, or edge-mode conversion timed out |

## Verification
The bench builds the reader with `HALF_CYC` = 2, `CONV_CYC` = 20 and `GAP_CYC` = 6, so that one read takes about 75 system cycles. At that cost a sweep over every eleventh code of the 4096-code range can run, plus the all-zeros, all-ones and alternating patterns, with edge and timeout modes alternating and the conversion delay varied. `HALF_CYC` = 2 is also the shortest phase at which a converter model that answers one cycle after a falling edge still meets the next capture. The small `CONV_CYC` makes the timeout abort, the exact start-to-first-clock latency and the chip-select-high interval cheap to measure cycle by cycle.

// File: rtl/adcRdPkg.sv
package adcRdPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic bitClr;
    logic bitInc;
    logic capture;
    logic publish;
  } rdStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic halfDone;
    logic convDone;
    logic gapDone;
    logic lastBit;
    logic leadBit;
  } rdStatus_t;

endpackage

// File: rtl/adcRdPath.sv
module adcRdPath
  import adcRdPkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int HALF_CYC = 13,
  parameter int CONV_CYC = 1063,
  parameter int GAP_CYC  = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  rdStrobe_t         strobe,
  output rdStatus_t         status,
  output logic [DATA_W-1:0] result
);

  localparam int FRAME_W = DATA_W + 1;
  localparam int TMAX    = (CONV_CYC > GAP_CYC) ?
                           ((CONV_CYC > HALF_CYC) ? CONV_CYC : HALF_CYC) :
                           ((GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC);
  localparam int TW      = $clog2(TMAX + 1);
  localparam int BW      = $clog2(FRAME_W + 1);
  localparam logic [TW-1:0] HALF_LAST = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] CONV_LAST = TW'(CONV_CYC - 1);
  localparam logic [TW-1:0] GAP_LAST  = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] T_TOP     = TW'(TMAX);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_W - 1);

  logic [TW-1:0]      timer;
  logic [BW-1:0]      bitCnt;
  logic [FRAME_W-1:0] frame;

  // one shared interval timer for phase, conversion and gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timer <= '0;
    else if (strobe.timerClr) timer <= '0;
    else if (timer != T_TOP)  timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bitCnt <= '0;
    else if (strobe.bitClr) bitCnt <= '0;
    else if (strobe.bitInc) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               frame <= '0;
    else if (strobe.capture) frame <= {frame[FRAME_W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               result <= '0;
    else if (strobe.publish) result <= frame[DATA_W-1:0];
  end

  always_comb begin
    status.halfDone = (timer == HALF_LAST);
    status.convDone = (timer == CONV_LAST);
    status.gapDone  = (timer == GAP_LAST);
    status.lastBit  = (bitCnt == BIT_LAST);
    status.leadBit  = frame[FRAME_W-1];
  end

  // R5: the bit counter never runs past the thirteenth cycle
  a_r5_bit_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_LAST);

  // R7: a sample is published only after the full frame was clocked
  a_r7_publish_full_frame: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |-> bitCnt == BIT_LAST);

endmodule

// File: rtl/adcRdCtrl.sv
module adcRdCtrl
  import adcRdPkg::*;
#(
  parameter int GAP_CYC = 63
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      edgeMode,
  input  logic      sdi,
  input  rdStatus_t status,
  output rdStrobe_t strobe,
  output logic      csN,
  output logic      sclk,
  output logic      valid,
  output logic      busy,
  output logic      frameErr
);

  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] GAP_SAT = CW'(GAP_CYC);

  rdState_t state, stateNext;
  logic     timeoutAbort;

  always_comb begin
    stateNext    = state;
    strobe       = '0;
    timeoutAbort = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext       = ST_CONV;
          strobe.timerClr = 1'b1;
        end
      end
      ST_CONV: begin
        if (edgeMode && sdi) begin
          stateNext       = ST_LOW;
          strobe.timerClr = 1'b1;
          strobe.bitClr   = 1'b1;
        end else if (status.convDone) begin
          strobe.timerClr = 1'b1;
          if (edgeMode) begin
            stateNext    = ST_GAP;
            timeoutAbort = 1'b1;
          end else begin
            stateNext     = ST_LOW;
            strobe.bitClr = 1'b1;
          end
        end
      end
      ST_LOW: begin
        if (status.halfDone) begin
          stateNext       = ST_HIGH;
          strobe.timerClr = 1'b1;
          strobe.capture  = 1'b1;
        end
      end
      ST_HIGH: begin
        if (status.halfDone) begin
          strobe.timerClr = 1'b1;
          if (status.lastBit) begin
            stateNext      = ST_GAP;
            strobe.publish = 1'b1;
          end else begin
            stateNext     = ST_LOW;
            strobe.bitInc = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (status.gapDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      valid    <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      state <= stateNext;
      csN   <= (stateNext == ST_IDLE) || (stateNext == ST_GAP);
      sclk  <= (stateNext == ST_HIGH);
      valid <= strobe.publish;
      if (state == ST_IDLE && start) frameErr <= 1'b0;
      else if (timeoutAbort)         frameErr <= 1'b1;
      else if (strobe.publish)       frameErr <= ~status.leadBit;
    end
  end

  assign busy = (state != ST_IDLE);

  // cycles chip select has been high, saturating, for the gap check
  logic [CW-1:0] csHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       csHighCnt <= GAP_SAT;
    else if (!csN)                   csHighCnt <= '0;
    else if (csHighCnt != GAP_SAT)   csHighCnt <= csHighCnt + 1'b1;
  end

  // R5: the serial clock only toggles while the converter is selected
  a_r5_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R2: the serial clock stays low while a conversion is running
  a_r2_sclk_low_conv: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV) |-> !sclk);

  // R7: the valid strobe lasts one cycle
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);

  // R7: chip select rises in the cycle the sample is delivered
  a_r7_cs_rise_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> $rose(csN));

  // R10: chip select never falls before the minimum high time
  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> csHighCnt >= GAP_SAT);

  // R10: the block reports busy whenever a transfer is active
  a_r10_busy_when_selected: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

endmodule

// File: rtl/adcSampleReader.sv
module adcSampleReader
  import adcRdPkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int HALF_CYC = 13,
  parameter int CONV_CYC = 1063,
  parameter int GAP_CYC  = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              edgeMode,
  input  logic              sdi,
  output logic              csN,
  output logic              sclk,
  output logic [DATA_W-1:0] result,
  output logic              valid,
  output logic              busy,
  output logic              frameErr
);

  rdStrobe_t strobe;
  rdStatus_t status;

  adcRdCtrl #(
    .GAP_CYC (GAP_CYC)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .edgeMode (edgeMode),
    .sdi      (sdi),
    .status   (status),
    .strobe   (strobe),
    .csN      (csN),
    .sclk     (sclk),
    .valid    (valid),
    .busy     (busy),
    .frameErr (frameErr)
  );

  adcRdPath #(
    .DATA_W   (DATA_W),
    .HALF_CYC (HALF_CYC),
    .CONV_CYC (CONV_CYC),
    .GAP_CYC  (GAP_CYC)
  ) path (
    .clk    (clk),
    .rstN   (rstN),
    .sdi    (sdi),
    .strobe (strobe),
    .status (status),
    .result (result)
  );

endmodule

// File: tb/adcSampleReader_test.sv
`timescale 1ns/1ps
module adcSampleReader_test;

  localparam int HALF_T = 2;
  localparam int CONV_T = 20;
  localparam int GAP_T  = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        edgeMode = 1'b0;
  logic        sdi = 1'b0;
  logic        csN, sclk, valid, busy, frameErr;
  logic [11:0] result;

  always #4 clk = ~clk;

  adcSampleReader #(
    .DATA_W(12), .HALF_CYC(HALF_T), .CONV_CYC(CONV_T), .GAP_CYC(GAP_T)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .edgeMode(edgeMode), .sdi(sdi),
    .csN(csN), .sclk(sclk), .result(result), .valid(valid), .busy(busy),
    .frameErr(frameErr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // converter model: answers one cycle after each observed change
  logic [11:0] modelSample = '0;
  logic        modelLead = 1'b1;
  int          modelDelay = 5;
  logic [11:0] outBits = '0;
  logic        mPrevCs = 1'b1, mPrevSclk = 1'b0, converting = 1'b0;
  int          convCnt = 0;

  always @(posedge clk) begin
    mPrevCs   <= csN;
    mPrevSclk <= sclk;
    if (csN) begin
      sdi        <= 1'b0;
      converting <= 1'b0;
    end else if (mPrevCs) begin
      sdi        <= 1'b0;
      converting <= 1'b1;
      convCnt    <= 0;
    end else if (converting) begin
      if (convCnt == modelDelay) begin
        sdi        <= modelLead;
        outBits    <= modelSample;
        converting <= 1'b0;
      end else convCnt <= convCnt + 1;
    end else if (mPrevSclk && !sclk) begin
      sdi     <= outBits[11];
      outBits <= {outBits[10:0], 1'b0};
    end
  end

  // port monitor, sampled at the falling clock edge
  int cyc = 0, rises = 0, firstRise = -1, sdiRise = -1, csFall = 0;
  int validCnt = 0, csHighBusy = 0, phaseBad = 0, runLen = 0;
  logic [11:0] gotResult = '0;
  logic csAtValid = 1'b0;
  logic pCs = 1'b1, pSclk = 1'b0, pSdi = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (pCs && !csN) begin
      rises = 0; firstRise = -1; sdiRise = -1; csFall = cyc;
      validCnt = 0; csHighBusy = 0; phaseBad = 0; runLen = 0;
    end
    if (!csN && !pSdi && sdi && sdiRise < 0) sdiRise = cyc;
    if (sclk && !pSclk) begin
      rises = rises + 1;
      if (firstRise < 0) firstRise = cyc;
      if (rises > 1 && runLen != HALF_T) phaseBad = phaseBad + 1;
      runLen = 1;
    end else if (!sclk && pSclk) begin
      if (runLen != HALF_T) phaseBad = phaseBad + 1;
      runLen = 1;
    end else runLen = runLen + 1;
    if (valid) begin
      validCnt  = validCnt + 1;
      gotResult = result;
      csAtValid = csN;
    end
    if (csN && busy) csHighBusy = csHighBusy + 1;
    pCs = csN; pSclk = sclk; pSdi = sdi;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic [11:0] s, input bit mode, input bit lead,
                        input int delay, input bit abort, input bit poke);
    modelSample = s; modelLead = lead; modelDelay = delay; edgeMode = mode;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    check("R2 busy after start", busy, 1);
    check("R2 csN low after start", csN, 0);
    if (poke) begin
      repeat (CONV_T + 10) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int w = 0; w < 3000 && busy; w++) begin
      @(negedge clk); #1;
    end
    check("R10 gap busy cycles", csHighBusy, GAP_T);
    if (abort) begin
      check("R9 no valid on timeout", validCnt, 0);
      check("R9 no sclk on timeout", rises, 0);
      check("R9 frameErr on timeout", frameErr, 1);
    end else begin
      check(poke ? "R2 one valid despite extra start" : "R7 one valid",
            validCnt, 1);
      check("R6 result", gotResult, s);
      check("R7 csN high with valid", csAtValid, 1);
      check("R8 frameErr", frameErr, lead ? 0 : 1);
      check("R5 rising edges", rises, 13);
      check("R5 phase lengths", phaseBad, 0);
      if (mode) check("R3 edge latency", firstRise - sdiRise, HALF_T + 1);
      else      check("R4 timeout latency", firstRise - csFall, CONV_T + HALF_T);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 csN", csN, 1);
    check("R1 sclk", sclk, 0);
    check("R1 valid", valid, 0);
    check("R1 busy", busy, 0);
    check("R1 frameErr", frameErr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 result", result, 0);
    check("R1 csN after release", csN, 1);

    // fixed patterns in both modes
    doRead(12'h000, 1'b1, 1'b1, 4, 1'b0, 1'b0);
    doRead(12'hFFF, 1'b0, 1'b1, 4, 1'b0, 1'b0);
    doRead(12'hAAA, 1'b1, 1'b1, 9, 1'b0, 1'b0);
    doRead(12'h555, 1'b0, 1'b1, 3, 1'b0, 1'b0);
    doRead(12'h800, 1'b1, 1'b1, 6, 1'b0, 1'b0);
    doRead(12'h001, 1'b0, 1'b1, 6, 1'b0, 1'b0);

    // R9 abort, then R8 flag cleared by the next read
    doRead(12'h123, 1'b1, 1'b1, 1000, 1'b1, 1'b0);
    doRead(12'h456, 1'b1, 1'b1, 5, 1'b0, 1'b0);

    // R8 zero marker in timeout mode
    doRead(12'hFFF, 1'b0, 1'b0, 5, 1'b0, 1'b0);
    doRead(12'h3C3, 1'b0, 1'b1, 5, 1'b0, 1'b0);

    // R2 start during a read is ignored
    doRead(12'h6B9, 1'b0, 1'b1, 4, 1'b0, 1'b1);
    doRead(12'h2D4, 1'b1, 1'b1, 4, 1'b0, 1'b1);

    // code sweep, alternating modes and varied conversion time
    for (int k = 0; k < 373; k++) begin
      doRead(12'((k * 11) % 4096), k[0], 1'b1, 3 + (k % 7), 1'b0, 1'b0);
    end
    doRead(12'hFFE, 1'b1, 1'b1, 8, 1'b0, 1'b0);

    finish();
  end

endmodule